// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Mode

This block is a 16-bit up-counter with a companion 16-bit holding register. It counts either a clock-enable pulse that arrives once per twelve oscillator periods or falling edges on an external count pin. It works in one of three modes. In reload mode, a wrap reloads the count from the holding register. In capture mode, a falling edge on a trigger pin copies the running count into the holding register. In baud mode, the block acts as a reload timer whose wraps feed a serial bit-rate tick.

Software reaches the block through three plain registers, each with a write strobe and a read port: an 8-bit control word, the count and the holding register. The control word also carries two sticky flags. The hardware sets them and only a software write clears them. Two outputs report wraps as single-cycle pulses: one for every wrap, and one for wraps that happen in baud mode.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the count, the holding register and the control word read 0, and both pulse outputs are low.
- R2: The control word has these bits: bit 0 run, bit 1 source (1 = external pin), bit 2 capture select, bit 3 trigger enable, bit 4 receive-rate select, bit 5 transmit-rate select, bit 6 wrap flag, bit 7 trigger flag. With run=1 and source=0, the count rises by one at each clock edge where `tick12_en` is high, and at no other edge.
- R3: With run=1 and source=1, `tick12_en` is ignored. The count rises by one for each falling edge of `ext_cnt_pin`. A falling edge means the pin is sampled high at one clock edge and low at the next, and the count rises at the edge after the low sample.
- R4: With run=0 the count holds its value.
- R5: In reload mode (capture select 0 and both rate selects 0), an increment from 0xFFFF loads the count from the holding register. It also sets the wrap flag and raises `ovf_pulse` for one cycle, and `baud_tick` stays low.
- R6: In capture mode (capture select 1, both rate selects 0), an increment from 0xFFFF gives a count of 0, sets the wrap flag and pulses `ovf_pulse`. The holding register does not change.
- R7: In capture mode with trigger enable 1, a falling edge on `trig_pin` sets the trigger flag. It also copies into the holding register the count that is present in the cycle after the edge at which the pin is first sampled low.
- R8: In reload mode with trigger enable 1, a falling edge on `trig_pin` sets the trigger flag and loads the count from the holding register.
- R9: With trigger enable 0, a falling edge on `trig_pin` sets no flag and changes neither the count nor the holding register.
- R10: When either rate select is 1, the block runs in reload mode whatever the capture select says. A wrap then reloads the count and pulses both `ovf_pulse` and `baud_tick`, but does not set the wrap flag. A trigger edge, if enabled, reloads the count and does not capture.
- R11: Both flags stay set until software writes 0 to them. A flag set by hardware at the same edge as a software write of 0 ends up set.
- R12: A software write to the count or to the holding register takes effect over any hardware update to that register at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick12_en | input | 1 | Clock enable at oscillator/12, the timer source |
| ext_cnt_pin | input | 1 | External count pin |
| trig_pin | input | 1 | External capture/reload trigger pin |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word write data |
| ctrl_rdata | output | 8 | Control word read data |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Count write data |
| cnt_rdata | output | 16 | Current count |
| cap_wr | input | 1 | Holding register write strobe |
| cap_wdata | input | 16 | Holding register write data |
| cap_rdata | output | 16 | Holding register value |
| ovf_pulse | output | 1 | One-cycle pulse on each wrap from 0xFFFF |
| baud_tick | output | 1 | One-cycle pulse on each wrap in baud mode |

## Verification
The timer source is driven with an irregular enable pattern and checked every cycle, which separates counting enables from counting clocks. The external source is driven with a 32-bit bit pattern and compared with the number of high-to-low transitions, so a design that counts rises or levels gives a different total. Wraps are swept over holding values 0, a middle value, 0xFFFE and 0xFFFF. The last one forces back-to-back wraps. The same wrap is repeated in capture mode and under each rate select, so that reloading, wrapping to zero and flag suppression each give distinct counts and flags. Trigger edges are applied with the trigger enabled and disabled, in each mode and while counting. This separates capture from reload and checks the latency of the capture.

// File: rtl/crt_pkg.sv
`timescale 1ns/1ps
package crt_pkg;
    // Control word layout, most significant bit first
    typedef struct packed {
        logic trig_flag;   // bit 7
        logic wrap_flag;   // bit 6
        logic tx_rate;     // bit 5
        logic rx_rate;     // bit 4
        logic trig_en;     // bit 3
        logic cap_sel;     // bit 2
        logic src_ext;     // bit 1
        logic run;         // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/crt_fall_det.sv
`timescale 1ns/1ps
module crt_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    typedef struct packed {
        logic cur;
        logic prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.cur  = pin_i;
        smp_d.prev = smp_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    // high at one sample, low at the next
    assign fall_o = smp_q.prev & ~smp_q.cur;
endmodule

// File: rtl/crt_ctrl_reg.sv
`timescale 1ns/1ps
module crt_ctrl_reg
    import crt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_i,
    input  ctrl_t wdata_i,
    input  logic  set_wrap_i,
    input  logic  set_trig_i,
    output ctrl_t ctrl_o
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i)       ctrl_d = wdata_i;
        // hardware setting wins over a software clear in the same cycle
        if (set_wrap_i) ctrl_d.wrap_flag = 1'b1;
        if (set_trig_i) ctrl_d.trig_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/crt_count_core.sv
`timescale 1ns/1ps
module crt_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             trig_i,
    input  logic             cap_mode_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             cap_wr_i,
    input  logic [CNT_W-1:0] cap_wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
    } core_t;

    core_t core_d, core_q;
    logic  wrap;

    always_comb begin
        core_d = core_q;
        wrap   = inc_i && (core_q.cnt == TOP);

        if (trig_i && !cap_mode_i) begin
            core_d.cnt = core_q.hold;
        end else if (inc_i) begin
            if (wrap) core_d.cnt = cap_mode_i ? '0 : core_q.hold;
            else      core_d.cnt = core_q.cnt + 1'b1;
        end

        if (trig_i && cap_mode_i) core_d.hold = core_q.cnt;

        // software writes take priority
        if (cnt_wr_i) core_d.cnt  = cnt_wdata_i;
        if (cap_wr_i) core_d.hold = cap_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign cnt_o  = core_q.cnt;
    assign cap_o  = core_q.hold;
    assign wrap_o = wrap;
endmodule

// File: rtl/cap_reload_timer.sv
`timescale 1ns/1ps
module cap_reload_timer
    import crt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick12_en,
    input  logic              ext_cnt_pin,
    input  logic              trig_pin,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [CNT_W-1:0]  cnt_rdata,
    input  logic              cap_wr,
    input  logic [CNT_W-1:0]  cap_wdata,
    output logic [CNT_W-1:0]  cap_rdata,
    output logic              ovf_pulse,
    output logic              baud_tick
);
    localparam int N_PINS  = 2;
    localparam int PIN_EXT = 0;
    localparam int PIN_TRG = 1;

    typedef struct packed {
        logic wrap;
        logic baud;
    } pulse_t;

    ctrl_t             ctrl;
    logic [N_PINS-1:0] pins;
    logic [N_PINS-1:0] falls;
    logic              baud_mode, cap_mode, inc, trig_evt, wrap;
    pulse_t            pulse_d, pulse_q;

    assign pins[PIN_EXT] = ext_cnt_pin;
    assign pins[PIN_TRG] = trig_pin;

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        crt_fall_det u_fall (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pins[g]),
            .fall_o (falls[g])
        );
    end

    always_comb begin
        baud_mode = ctrl.rx_rate | ctrl.tx_rate;
        cap_mode  = ctrl.cap_sel & ~baud_mode;
        inc       = ctrl.run & (ctrl.src_ext ? falls[PIN_EXT] : tick12_en);
        trig_evt  = ctrl.trig_en & falls[PIN_TRG];
        pulse_d   = pulse_q;
        pulse_d.wrap = wrap;
        pulse_d.baud = wrap & baud_mode;
    end

    crt_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (ctrl_wr),
        .wdata_i    (ctrl_t'(ctrl_wdata)),
        .set_wrap_i (wrap & ~baud_mode),
        .set_trig_i (trig_evt),
        .ctrl_o     (ctrl)
    );

    crt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_i       (inc),
        .trig_i      (trig_evt),
        .cap_mode_i  (cap_mode),
        .cnt_wr_i    (cnt_wr),
        .cnt_wdata_i (cnt_wdata),
        .cap_wr_i    (cap_wr),
        .cap_wdata_i (cap_wdata),
        .cnt_o       (cnt_rdata),
        .cap_o       (cap_rdata),
        .wrap_o      (wrap)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= pulse_d;
    end

    assign ctrl_rdata = ctrl;
    assign ovf_pulse  = pulse_q.wrap;
    assign baud_tick  = pulse_q.baud;
endmodule

// File: rtl/crt_checker.sv
`timescale 1ns/1ps
module crt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic [7:0]       ctrl_rdata,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_rdata,
    input logic             cap_wr,
    input logic [CNT_W-1:0] cap_rdata,
    input logic             ovf_pulse,
    input logic             baud_tick
);
    assert_run_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rdata[0] && !cnt_wr && !ctrl_rdata[3]) |=> $stable(cnt_rdata));

    assert_baud_has_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> ovf_pulse);

    assert_wrap_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctrl_rdata[6]) && !$past(ctrl_wr)) |-> (ovf_pulse && !baud_tick));

    assert_wrap_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[6] && !ctrl_wr) |=> ctrl_rdata[6]);

    assert_trig_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[7] && !ctrl_wr) |=> ctrl_rdata[7]);

    assert_hold_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_wr && !ctrl_rdata[3]) |=> $stable(cap_rdata));
endmodule

bind cap_reload_timer crt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_rdata (ctrl_rdata),
    .cnt_wr     (cnt_wr),
    .cnt_rdata  (cnt_rdata),
    .cap_wr     (cap_wr),
    .cap_rdata  (cap_rdata),
    .ovf_pulse  (ovf_pulse),
    .baud_tick  (baud_tick)
);

// File: tb/tb_cap_reload_timer.sv
`timescale 1ns/1ps
module tb_cap_reload_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick12_en = 1'b0, ext_cnt_pin = 1'b0, trig_pin = 1'b1;
    logic        ctrl_wr = 1'b0, cnt_wr = 1'b0, cap_wr = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [15:0] cnt_wdata = '0, cap_wdata = '0;
    logic [7:0]  ctrl_rdata;
    logic [15:0] cnt_rdata, cap_rdata;
    logic        ovf_pulse, baud_tick;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    cap_reload_timer dut (
        .clk(clk), .rst_n(rst_n), .tick12_en(tick12_en), .ext_cnt_pin(ext_cnt_pin),
        .trig_pin(trig_pin), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cnt_rdata(cnt_rdata), .cap_wr(cap_wr), .cap_wdata(cap_wdata),
        .cap_rdata(cap_rdata), .ovf_pulse(ovf_pulse), .baud_tick(baud_tick)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic nxt(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v; nxt(); ctrl_wr = 1'b0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        cnt_wr = 1'b1; cnt_wdata = v; nxt(); cnt_wr = 1'b0;
    endtask

    task automatic wr_cap(input logic [15:0] v);
        cap_wr = 1'b1; cap_wdata = v; nxt(); cap_wr = 1'b0;
    endtask

    task automatic trig_fall();
        trig_pin = 1'b0; nxt(2); trig_pin = 1'b1; nxt(2);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_cnt;
        logic [15:0] holds [4];
        logic [31:0] pat;
        int          falls;
        logic        prev;
        logic [15:0] v;

        holds[0] = 16'h0000; holds[1] = 16'h1234; holds[2] = 16'hFFFE; holds[3] = 16'hFFFF;
        nxt(3);
        rst_n = 1'b1;
        nxt();
        // R1 reset state
        chk("R1 count", cnt_rdata, 0);
        chk("R1 hold", cap_rdata, 0);
        chk("R1 ctrl", ctrl_rdata, 0);
        chk("R1 pulses", {ovf_pulse, baud_tick}, 0);

        // R2 timer source with irregular enable
        wr_ctrl(8'h01);
        chk("R2 ctrl readback", ctrl_rdata, 8'h01);
        exp_cnt = 0;
        for (int i = 0; i < 40; i++) begin
            tick12_en = ((i * 7) % 3) != 0;
            nxt();
            if (tick12_en) exp_cnt++;
            chk("R2 timer count", cnt_rdata, exp_cnt);
        end

        // R4 run cleared holds count
        tick12_en = 1'b1;
        wr_ctrl(8'h00);
        exp_cnt = cnt_rdata;
        nxt(10);
        chk("R4 hold with run=0", cnt_rdata, exp_cnt);

        // R3 external source, tick12 ignored
        wr_cnt(16'h0000);
        wr_ctrl(8'h03);
        pat = 32'hB3A5_6D19; falls = 0; prev = 1'b0;
        for (int i = 0; i < 32; i++) begin
            ext_cnt_pin = pat[i];
            if (prev && !pat[i]) falls++;
            prev = pat[i];
            nxt();
        end
        ext_cnt_pin = 1'b1;
        nxt(3);
        chk("R3 external falling edges", cnt_rdata, falls);
        ext_cnt_pin = 1'b0;
        nxt(3);
        chk("R3 final edge", cnt_rdata, falls + 1);

        // R5 reload-mode wraps, swept over hold values
        tick12_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            wr_ctrl(8'h00);
            wr_cap(holds[k]);
            wr_cnt(16'hFFFE);
            wr_ctrl(8'h01);
            chk("R5 pre", cnt_rdata, 16'hFFFE);
            nxt();
            chk("R5 at top", cnt_rdata, 16'hFFFF);
            nxt();
            chk("R5 reload", cnt_rdata, holds[k]);
            chk("R5 pulse/baud/flag", {ovf_pulse, baud_tick, ctrl_rdata[6]}, 3'b101);
            nxt();
            if (holds[k] == 16'hFFFF) begin
                chk("R5 back-to-back wrap", {cnt_rdata, 15'd0, ovf_pulse}, {16'hFFFF, 16'h0001});
            end else begin
                chk("R5 after wrap", {cnt_rdata, 15'd0, ovf_pulse}, {holds[k] + 16'h1, 16'h0000});
            end
        end

        // R11 flag stays until software clear
        wr_ctrl(8'h40);
        nxt(5);
        chk("R11 sticky wrap flag", ctrl_rdata[6], 1'b1);
        wr_ctrl(8'h00);
        chk("R11 software clear", ctrl_rdata[6], 1'b0);
        // R11 hardware set vs simultaneous software clear
        tick12_en = 1'b0;
        wr_cap(16'h0000);
        wr_ctrl(8'h01);
        wr_cnt(16'hFFFF);
        tick12_en = 1'b1; ctrl_wr = 1'b1; ctrl_wdata = 8'h01;
        nxt();
        ctrl_wr = 1'b0;
        chk("R11 hw set beats sw clear", ctrl_rdata, 8'h41);

        // R6 capture-mode wrap to zero
        wr_ctrl(8'h00);
        wr_cap(16'h5555);
        wr_cnt(16'hFFFE);
        wr_ctrl(8'h05);
        nxt();
        chk("R6 at top", cnt_rdata, 16'hFFFF);
        nxt();
        chk("R6 wrap to zero", cnt_rdata, 16'h0000);
        chk("R6 flag/pulse", {ctrl_rdata[6], ovf_pulse}, 2'b11);
        chk("R6 hold unchanged", cap_rdata, 16'h5555);

        // R7 capture with counter stopped
        wr_ctrl(8'h0C);
        wr_cnt(16'h2345);
        trig_fall();
        chk("R7 captured idle", cap_rdata, 16'h2345);
        chk("R7 trig flag", ctrl_rdata[7], 1'b1);
        // R7 capture while counting
        wr_ctrl(8'h0D);
        wr_cnt(16'h0100);
        for (int j = 0; j < 4; j++) begin
            nxt(j + 1);
            v = cnt_rdata;
            trig_pin = 1'b0;
            nxt(2);
            chk("R7 captured running", cap_rdata, v + 16'h1);
            trig_pin = 1'b1;
        end

        // R8 trigger reload in reload mode
        tick12_en = 1'b0;
        wr_ctrl(8'h09);
        wr_cap(16'h0ABC);
        wr_cnt(16'h0111);
        trig_fall();
        chk("R8 trigger reload", cnt_rdata, 16'h0ABC);
        chk("R8 trig flag", ctrl_rdata[7], 1'b1);

        // R9 trigger disabled
        wr_ctrl(8'h01);
        wr_cnt(16'h0222);
        trig_fall();
        chk("R9 count untouched", cnt_rdata, 16'h0222);
        chk("R9 no flag", ctrl_rdata[7], 1'b0);
        wr_ctrl(8'h05);
        trig_fall();
        chk("R9 hold untouched", cap_rdata, 16'h0ABC);

        // R10 baud mode under each rate select
        tick12_en = 1'b1;
        for (int s = 1; s < 4; s++) begin
            wr_ctrl(8'h00);
            wr_cap(16'hFFFC);
            wr_cnt(16'hFFFE);
            wr_ctrl(8'h05 | 8'(s << 4));
            nxt();
            chk("R10 at top", cnt_rdata, 16'hFFFF);
            nxt();
            chk("R10 reload despite capture select", cnt_rdata, 16'hFFFC);
            chk("R10 pulse/baud/flag", {ovf_pulse, baud_tick, ctrl_rdata[6]}, 3'b110);
            nxt();
            chk("R10 tick ends", {cnt_rdata, 14'd0, ovf_pulse, baud_tick}, {16'hFFFD, 16'h0000});
        end
        // R10 trigger reloads rather than captures
        tick12_en = 1'b0;
        wr_ctrl(8'h2C);
        wr_cap(16'h0777);
        wr_cnt(16'h0100);
        trig_fall();
        chk("R10 trigger reload count", cnt_rdata, 16'h0777);
        chk("R10 trigger hold kept", cap_rdata, 16'h0777);

        // R12 software write beats increment
        tick12_en = 1'b1;
        wr_ctrl(8'h01);
        wr_cnt(16'h4000);
        chk("R12 write priority", cnt_rdata, 16'h4000);
        nxt();
        chk("R12 resumes", cnt_rdata, 16'h4001);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule